// File: doc/BRIEF.md
# Flash Access Protection Controller

This block is the policy gate in front of a non-volatile memory array. Every request for an instruction fetch, data read, program or page erase carries its requester (CPU, DMA or debug) and a page index. The block answers, one cycle later, with exactly one of grant or deny. The answer depends on a readout protection level, on the boot source and debug-attach status, and on three kinds of address areas. These are write-locked areas defined on a 4 KB grain, execute-only areas defined on a 2 KB grain, and a region kept for a second processor that host-side requesters can never reach.

The protection level has three values. A change of level is requested through a small command port. Dropping from the middle level to the unrestricted level raises a one-cycle mass-erase request. A companion output tells the array whether the execute-only areas must be wiped as well. The top level is a one-way latch: any attempt to leave it is refused and recorded. A refused access sets a sticky error flag that holds the kind of the most recent refused request. Software clears either flag by writing a 1 to its clear bit.

Top module: `flash_guard`

## Requirements
- R1: After reset the level is 0 (`level` = 0), and grant, deny, acc_err, acc_err_kind, lvl_err, mass_erase and mass_erase_xo are all 0.
- R2: At level 0 a request is granted whatever boot_sel and dbg_attached are, unless it falls in one of the areas named in R6, R7 or R8.
- R3: At level 1 every request is denied while dbg_attached is 1, while boot_sel is not 0 (0 = user flash, 1 = SRAM, 2 = loader, 3 = other), or when req_src is 2 (debug). The source codes are 0 = CPU, 1 = DMA, 2 = debug and 3 = another bus master.
- R4: At level 2 every request from req_src 2 is denied. boot_sel and dbg_attached have no effect at this level.
- R5: When the level is 2, a change request to code 0, 1 or 3 leaves the level at 2 and sets lvl_err. A request to code 2 changes nothing. Change codes 0, 1 and 2 select that level, and code 3 selects level 1. The new level appears on `level` one cycle after the request. lvl_err stays set until err_clr bit 1 is written, and a new refusal in the same cycle wins over the clear.
- R6: A program (req_kind 2) or erase (req_kind 3) request is denied when its page lies in a write-locked area. A page p lies in area i when wp_lo[i] <= p/2 <= wp_hi[i], the bounds being in 4 KB units. Fetch (0) and read (1) requests are not affected by these areas.
- R7: Within an execute-only area (xo_lo[i] <= page <= xo_hi[i], in 2 KB pages) only a fetch from req_src 0 is granted. Every other request there is denied.
- R8: Every request whose page lies in rsv_lo..rsv_hi is denied at any level.
- R9: An area whose upper bound is below its lower bound covers no page.
- R10: A change request from level 1 to level 0 pulses mass_erase for one cycle, in the cycle in which `level` first reads 0. mass_erase_xo pulses with it when xo_wipe was 1 at the request. No other change of level raises either output.
- R11: A denied request sets acc_err in the same cycle as deny and loads acc_err_kind with its req_kind. acc_err clears when err_clr bit 0 is written, unless a denial arrives in the same cycle.
- R12: A request with req_valid = 1 yields exactly one of grant or deny in the next cycle. Without a request both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access request is present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 program, 3 erase |
| req_src | input | 2 | 0 CPU, 1 DMA, 2 debug, 3 other master |
| req_page | input | PAGE_W | 2 KB page index of the access |
| boot_sel | input | 2 | 0 user flash, 1 SRAM, 2 loader, 3 other |
| dbg_attached | input | 1 | Debug probe connected |
| wp_lo | input | NUM_AREAS*(PAGE_W-1) | Write-locked area lower bounds, 4 KB units |
| wp_hi | input | NUM_AREAS*(PAGE_W-1) | Write-locked area upper bounds, 4 KB units |
| xo_lo | input | NUM_AREAS*PAGE_W | Execute-only area lower bounds, pages |
| xo_hi | input | NUM_AREAS*PAGE_W | Execute-only area upper bounds, pages |
| rsv_lo | input | PAGE_W | Second-processor region lower bound |
| rsv_hi | input | PAGE_W | Second-processor region upper bound |
| xo_wipe | input | 1 | Include execute-only areas in the level-drop erase |
| lvl_chg_valid | input | 1 | Level change request |
| lvl_chg_code | input | 2 | Requested level code |
| err_clr | input | 2 | Write-1 clear: bit 0 acc_err, bit 1 lvl_err |
| grant | output | 1 | Previous request allowed |
| deny | output | 1 | Previous request refused |
| acc_err | output | 1 | Sticky access refusal flag |
| acc_err_kind | output | 2 | req_kind of the latest refused request |
| lvl_err | output | 1 | Sticky refused level change flag |
| level | output | 2 | Current protection level |
| mass_erase | output | 1 | One-cycle mass erase request |
| mass_erase_xo | output | 1 | Erase also covers execute-only areas |

## Verification
Each result is due one cycle after the edge that samples the request or command. grant, deny, acc_err and acc_err_kind follow a request by one cycle, and level, lvl_err and mass_erase follow a change command by one cycle. The reference model advances on the same rising edge as the design, using the levels held before that edge, so its expectations already include the one-register delay. Inputs change on the falling edge, and all outputs are compared against the model on the falling edge too, half a cycle after they settle. A change command and an access in the same cycle are therefore judged against the old level in both model and design.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
    typedef enum logic [1:0] {OP_FETCH = 2'd0, OP_READ = 2'd1, OP_PROG = 2'd2, OP_ERASE = 2'd3} op_e;
    typedef enum logic [1:0] {SRC_CPU = 2'd0, SRC_DMA = 2'd1, SRC_DBG = 2'd2, SRC_OTHER = 2'd3} src_e;
    typedef enum logic [1:0] {BOOT_FLASH = 2'd0, BOOT_SRAM = 2'd1, BOOT_LOADER = 2'd2, BOOT_OTHER = 2'd3} boot_e;
    typedef enum logic [1:0] {LVL_OPEN = 2'd0, LVL_GUARD = 2'd1, LVL_LOCK = 2'd2, LVL_ALIAS = 2'd3} lvl_e;
endpackage

// File: rtl/flash_guard_span.sv
module flash_guard_span #(
    parameter int W = 8
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // an inverted span (hi < lo) covers nothing
    assign hit = (lo <= hi) && (idx >= lo) && (idx <= hi);
endmodule

// File: rtl/flash_guard_policy.sv
module flash_guard_policy
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int NUM_AREAS = 2,
    localparam int WP_W     = PAGE_W - 1
) (
    input  op_e                                op,
    input  src_e                               src,
    input  logic [PAGE_W-1:0]                  page,
    input  boot_e                              boot,
    input  logic                               dbg,
    input  lvl_e                               lvl,
    input  logic [NUM_AREAS-1:0][WP_W-1:0]     wp_lo,
    input  logic [NUM_AREAS-1:0][WP_W-1:0]     wp_hi,
    input  logic [NUM_AREAS-1:0][PAGE_W-1:0]   xo_lo,
    input  logic [NUM_AREAS-1:0][PAGE_W-1:0]   xo_hi,
    input  logic [PAGE_W-1:0]                  rsv_lo,
    input  logic [PAGE_W-1:0]                  rsv_hi,
    output logic                               ok
);
    logic [NUM_AREAS-1:0] wp_hit;
    logic [NUM_AREAS-1:0] xo_hit;
    logic                 rsv_hit;
    logic [WP_W-1:0]      wp_idx;

    assign wp_idx = page[PAGE_W-1:1];

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
        flash_guard_span #(.W(WP_W)) u_wp (
            .idx(wp_idx), .lo(wp_lo[i]), .hi(wp_hi[i]), .hit(wp_hit[i]));
        flash_guard_span #(.W(PAGE_W)) u_xo (
            .idx(page), .lo(xo_lo[i]), .hi(xo_hi[i]), .hit(xo_hit[i]));
    end

    flash_guard_span #(.W(PAGE_W)) u_rsv (
        .idx(page), .lo(rsv_lo), .hi(rsv_hi), .hit(rsv_hit));

    always_comb begin
        ok = 1'b1;
        if (rsv_hit) ok = 1'b0;
        case (lvl)
            LVL_OPEN: ;
            LVL_LOCK: if (src == SRC_DBG) ok = 1'b0;
            default:  if (dbg || boot != BOOT_FLASH || src == SRC_DBG) ok = 1'b0;
        endcase
        if (|xo_hit && !(op == OP_FETCH && src == SRC_CPU)) ok = 1'b0;
        if (|wp_hit && (op == OP_PROG || op == OP_ERASE)) ok = 1'b0;
    end
endmodule

// File: rtl/flash_guard_level.sv
module flash_guard_level
    import flash_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_valid,
    input  logic [1:0] chg_code,
    input  logic       xo_wipe,
    input  logic       clr,
    output lvl_e       lvl,
    output logic       lvl_err,
    output logic       erase,
    output logic       erase_xo
);
    typedef struct packed {
        lvl_e lvl;
        logic err;
        logic er;
        logic erx;
    } lstate_t;

    lstate_t s_d, s_q;
    lvl_e    tgt;

    always_comb begin
        s_d     = s_q;
        s_d.er  = 1'b0;
        s_d.erx = 1'b0;
        tgt     = (chg_code == 2'd3) ? LVL_GUARD : lvl_e'(chg_code);
        if (clr) s_d.err = 1'b0;
        if (chg_valid) begin
            if (s_q.lvl == LVL_LOCK) begin
                if (tgt != LVL_LOCK) s_d.err = 1'b1;
            end else begin
                s_d.lvl = tgt;
                if (s_q.lvl == LVL_GUARD && tgt == LVL_OPEN) begin
                    s_d.er  = 1'b1;
                    s_d.erx = xo_wipe;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{lvl: LVL_OPEN, err: 1'b0, er: 1'b0, erx: 1'b0};
        else        s_q <= s_d;
    end

    assign lvl      = s_q.lvl;
    assign lvl_err  = s_q.err;
    assign erase    = s_q.er;
    assign erase_xo = s_q.erx;

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_LOCK) |=> (lvl == LVL_LOCK));
    // R10
    erase_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |-> (lvl == LVL_OPEN && $past(lvl) == LVL_GUARD));
    // R10
    erase_xo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_xo |-> erase);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int NUM_AREAS = 2,
    localparam int WP_W     = PAGE_W - 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic [1:0]                         req_kind,
    input  logic [1:0]                         req_src,
    input  logic [PAGE_W-1:0]                  req_page,
    input  logic [1:0]                         boot_sel,
    input  logic                               dbg_attached,
    input  logic [NUM_AREAS-1:0][WP_W-1:0]     wp_lo,
    input  logic [NUM_AREAS-1:0][WP_W-1:0]     wp_hi,
    input  logic [NUM_AREAS-1:0][PAGE_W-1:0]   xo_lo,
    input  logic [NUM_AREAS-1:0][PAGE_W-1:0]   xo_hi,
    input  logic [PAGE_W-1:0]                  rsv_lo,
    input  logic [PAGE_W-1:0]                  rsv_hi,
    input  logic                               xo_wipe,
    input  logic                               lvl_chg_valid,
    input  logic [1:0]                         lvl_chg_code,
    input  logic [1:0]                         err_clr,
    output logic                               grant,
    output logic                               deny,
    output logic                               acc_err,
    output logic [1:0]                         acc_err_kind,
    output logic                               lvl_err,
    output logic [1:0]                         level,
    output logic                               mass_erase,
    output logic                               mass_erase_xo
);
    typedef struct packed {
        logic       grant;
        logic       deny;
        logic       err;
        logic [1:0] kind;
    } astate_t;

    astate_t s_d, s_q;
    lvl_e    cur_lvl;
    logic    ok;

    flash_guard_level u_level (
        .clk(clk), .rst_n(rst_n), .chg_valid(lvl_chg_valid), .chg_code(lvl_chg_code),
        .xo_wipe(xo_wipe), .clr(err_clr[1]), .lvl(cur_lvl), .lvl_err(lvl_err),
        .erase(mass_erase), .erase_xo(mass_erase_xo));

    flash_guard_policy #(.PAGE_W(PAGE_W), .NUM_AREAS(NUM_AREAS)) u_policy (
        .op(op_e'(req_kind)), .src(src_e'(req_src)), .page(req_page),
        .boot(boot_e'(boot_sel)), .dbg(dbg_attached), .lvl(cur_lvl),
        .wp_lo(wp_lo), .wp_hi(wp_hi), .xo_lo(xo_lo), .xo_hi(xo_hi),
        .rsv_lo(rsv_lo), .rsv_hi(rsv_hi), .ok(ok));

    always_comb begin
        s_d       = s_q;
        s_d.grant = req_valid && ok;
        s_d.deny  = req_valid && !ok;
        if (err_clr[0]) s_d.err = 1'b0;
        if (req_valid && !ok) begin
            s_d.err  = 1'b1;
            s_d.kind = req_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant        = s_q.grant;
    assign deny         = s_q.deny;
    assign acc_err      = s_q.err;
    assign acc_err_kind = s_q.kind;
    assign level        = cur_lvl;

    // R12
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant ^ deny));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !deny));
    // R11
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> acc_err);
    // R8
    rsv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsv_lo <= rsv_hi && req_page >= rsv_lo && req_page <= rsv_hi) |=> !grant);
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, dbg_attached = 0, xo_wipe = 0, lvl_chg_valid = 0;
    logic [1:0] req_kind = 0, req_src = 0, boot_sel = 0, lvl_chg_code = 0, err_clr = 0;
    logic [PW-1:0] req_page = 0;
    logic [1:0][PW-2:0] wp_lo, wp_hi;
    logic [1:0][PW-1:0] xo_lo, xo_hi;
    logic [PW-1:0] rsv_lo, rsv_hi;
    logic grant, deny, acc_err, lvl_err, mass_erase, mass_erase_xo;
    logic [1:0] acc_err_kind, level;

    flash_guard uut (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0;
    string tag = "R1";

    // reference model state
    int m_lvl = 0;
    bit e_grant = 0, e_deny = 0, e_err = 0, e_lerr = 0, e_me = 0, e_mex = 0;
    int e_kind = 0;

    function automatic bit in_rng(int p, int lo, int hi);
        return (lo <= hi) && (p >= lo) && (p <= hi);
    endfunction

    function automatic bit allowed(int kind, int src, int page, int boot, bit dbg, int lv);
        bit a = 1;
        bit in_wp = 0, in_xo = 0;
        for (int i = 0; i < 2; i++) begin
            if (wp_lo[i] <= wp_hi[i] && page >= 2 * wp_lo[i] && page <= 2 * wp_hi[i] + 1) in_wp = 1;
            if (in_rng(page, xo_lo[i], xo_hi[i])) in_xo = 1;
        end
        if (in_rng(page, rsv_lo, rsv_hi)) a = 0;
        if (lv == 1 && (dbg || boot != 0 || src == 2)) a = 0;
        if (lv == 2 && src == 2) a = 0;
        if (in_xo && !(kind == 0 && src == 0)) a = 0;
        if (in_wp && kind >= 2) a = 0;
        return a;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_lvl = 0; e_grant = 0; e_deny = 0; e_err = 0; e_kind = 0;
            e_lerr = 0; e_me = 0; e_mex = 0;
        end else begin
            bit a;
            int tgt;
            a = allowed(req_kind, req_src, req_page, boot_sel, dbg_attached, m_lvl);
            e_grant = req_valid && a;
            e_deny  = req_valid && !a;
            if (err_clr[0]) e_err = 0;
            if (req_valid && !a) begin e_err = 1; e_kind = req_kind; end
            e_me = 0; e_mex = 0;
            if (err_clr[1]) e_lerr = 0;
            if (lvl_chg_valid) begin
                tgt = (lvl_chg_code == 3) ? 1 : lvl_chg_code;
                if (m_lvl == 2) begin
                    if (tgt != 2) e_lerr = 1;
                end else begin
                    if (m_lvl == 1 && tgt == 0) begin e_me = 1; e_mex = xo_wipe; end
                    m_lvl = tgt;
                end
            end
        end
        started = 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: act hung, exp finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cmp(string rq, string nm, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: act %0d exp %0d (cycle %0d)", rq, nm, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started && rst_n) begin
            cmp(tag,   "grant", grant, e_grant);
            cmp("R12", "deny", deny, e_deny);
            cmp("R11", "acc_err", acc_err, e_err);
            cmp("R11", "acc_err_kind", acc_err_kind, e_kind);
            cmp("R5",  "level", level, m_lvl);
            cmp("R5",  "lvl_err", lvl_err, e_lerr);
            cmp("R10", "mass_erase", mass_erase, e_me);
            cmp("R10", "mass_erase_xo", mass_erase_xo, e_mex);
        end
    end

    // mode: 0 any page, 1 write-locked, 2 execute-only, 3 reserved, 4 disabled area, 5 mix
    function automatic int pick_page(int mode);
        int m = (mode == 5) ? $urandom % 5 : mode;
        case (m)
            1: return 18 + $urandom % 8;
            2: return ($urandom % 2) ? 38 + $urandom % 8 : 58 + $urandom % 5;
            3: return 198 + $urandom % 6;
            4: return 6 + $urandom % 8;
            default: return $urandom % 256;
        endcase
    endfunction

    task automatic run(string t, int n, int mode, bit vary_env);
        tag = t;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
            req_valid = ($urandom % 4) != 0;
            req_kind  = 2'($urandom);
            req_src   = 2'($urandom);
            req_page  = PW'(pick_page(mode));
            boot_sel  = vary_env ? 2'($urandom) : 2'd0;
            dbg_attached = vary_env ? 1'($urandom) : 1'b0;
            err_clr   = (($urandom % 6) == 0) ? 2'($urandom) : 2'd0;
        end
        @(negedge clk);
        #1;
        req_valid = 0; err_clr = 0;
    endtask

    task automatic change(int code, bit wipe, bit with_req);
        @(negedge clk);
        #1;
        lvl_chg_valid = 1; lvl_chg_code = 2'(code); xo_wipe = wipe;
        req_valid = with_req; req_kind = 2'd1; req_src = 2'd0; req_page = 8'd100;
        @(negedge clk);
        #1;
        lvl_chg_valid = 0; req_valid = 0;
    endtask

    initial begin
        wp_lo[0] = 7'd10; wp_hi[0] = 7'd11;   // pages 20..23
        wp_lo[1] = 7'd5;  wp_hi[1] = 7'd3;    // inverted: disabled (R9)
        xo_lo[0] = 8'd40; xo_hi[0] = 8'd43;
        xo_lo[1] = 8'd60; xo_hi[1] = 8'd60;
        rsv_lo = 8'd200;  rsv_hi = 8'd255;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        tag = "R1";
        cmp("R1", "level", level, 0);
        cmp("R1", "grant", grant, 0);
        cmp("R1", "deny", deny, 0);
        cmp("R1", "acc_err", acc_err, 0);
        cmp("R1", "acc_err_kind", acc_err_kind, 0);
        cmp("R1", "lvl_err", lvl_err, 0);
        cmp("R1", "mass_erase", mass_erase, 0);
        cmp("R1", "mass_erase_xo", mass_erase_xo, 0);

        run("R2", 300, 0, 1);
        run("R6", 200, 1, 0);
        run("R7", 200, 2, 0);
        run("R8", 100, 3, 1);
        run("R9", 150, 4, 0);
        run("R12", 100, 5, 0);
        change(1, 1, 1);          // 0 -> 1, no erase (R10)
        run("R3", 400, 5, 1);
        change(0, 1, 1);          // 1 -> 0, erase incl. execute-only (R10)
        run("R2", 50, 5, 1);
        change(0, 1, 0);          // 0 -> 0, no erase (R10)
        change(3, 0, 0);          // alias code 3 selects level 1
        run("R3", 100, 0, 1);
        change(0, 0, 0);          // 1 -> 0, erase without execute-only (R10)
        change(2, 0, 0);          // 0 -> 2
        run("R4", 400, 5, 1);
        change(0, 1, 1);          // refused (R5)
        run("R11", 60, 5, 1);
        change(2, 0, 0);          // no-op at level 2
        change(1, 0, 0);          // refused (R5)
        change(3, 1, 1);          // refused (R5)
        run("R5", 100, 5, 1);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule